// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers 64 level-sensitive interrupt lines and presents them to a processor as two request outputs, a normal one and a fast one. Each line has an enable bit, a routing bit that selects which output it drives, and a 4-bit priority. Software can also hold any line active through a force register, so a handler can be exercised without the real source. Status registers expose the raw input levels, the set of normal requests still pending after priority masking, and the set of fast requests pending.

The normal handler reads one vector register in a loop: its upper half names the pending normal source that wins arbitration (highest priority, higher number on a tie) and its lower half gives that source's priority, while the all-ones code 0xFFFF in the upper half tells the handler to stop. A mask level register lets software hold off normal requests at or below a chosen priority. Single lines are switched on or off by writing their number to a set register or a clear register, with no read-modify-write of the full enable word.

Access is through a simple 32-bit register port controlled by a two-state machine. In state S_IDLE a request is taken (transition S_IDLE to S_ACK on bus_req); in state S_ACK the acknowledge is high for exactly one cycle with any read data, and the machine always returns to S_IDLE (transition S_ACK to S_IDLE).

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the control word, every enable, routing, force and priority bit read 0, the mask level reads 0x1F, both request outputs are low and the normal vector reads 0xFFFF0000.
- R2: A request seen in S_IDLE is acknowledged in the following cycle with read data valid alongside; reads of unused offsets return 0 and writes to read-only offsets change nothing.
- R3: Per-line words come in pairs with lines 32 to 63 at the lower offset and lines 0 to 31 at the offset 4 above it: enable 0x10/0x14, routing 0x18/0x1C, raw input 0x48/0x4C, force 0x50/0x54, normal pending 0x58/0x5C, fast pending 0x60/0x64; control sits at 0x00 and mask level at 0x04.
- R4: A line is active when its input is high or its force bit is set, and pending when also enabled; the raw input words show the input pins only.
- R5: A routing bit of 1 sends the line to the fast output only; 0 sends it to the normal path only.
- R6: The priority word for group x (lines 8x to 8x+7) sits at offset 0x20 + 4*(7 - x), and line 8x+j uses bits 4j+3 down to 4j.
- R7: The normal vector at 0x40 holds the winning line number in bits 31:16 and its priority in bits 15:0, the winner being the highest priority with the higher line number breaking ties; with nothing pending it reads 0xFFFF0000.
- R8: A mask level m other than 0x1F removes normal lines of priority m or lower from normal pending, the normal output and the vector; 0x1F removes nothing; the fast path is never masked.
- R9: The fast vector at 0x44 holds the lowest-numbered fast-pending line in bits 31:16 (bits 15:0 zero), or 0xFFFF0000 when none is pending.
- R10: Writing n below 64 to 0x08 sets enable bit n, writing it to 0x0C clears it, a value of 64 or more is ignored, and both offsets read 0.
- R11: The normal output is the OR of the masked normal pending set and the fast output is the OR of the fast pending set.
- R12: The acknowledge is never high on two cycles in a row, and a request arriving while in S_ACK is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_src | input | 64 | Level-sensitive interrupt lines |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 7 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | One-cycle acknowledge |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| irq_norm | output | 1 | Normal interrupt request |
| irq_fast | output | 1 | Fast interrupt request |

## Verification
Arbitration is driven with two pending lines of equal priority, which separates a tie broken toward the higher number from one broken toward the lower, and then with a raised priority on the lower line, which shows priority outranks number. The mask level is stepped to exactly the winner's priority and one below it, telling an inclusive threshold from an exclusive one, and to a value just under 0x1F to show the fast path stays unmasked. Lines are activated both through the force words and through the pins so the two sources of activity, and the raw word that shows only pins, are kept apart. Set and clear by number are tried with in-range and out-of-range values in both register halves.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int NSRC   = 64;
    localparam int DW     = 32;
    localparam int PRIO_W = 4;
    localparam int AW     = 7;

    // register offsets; software depends on these positions
    localparam logic [AW-1:0] OFS_CTRL    = 7'h00;
    localparam logic [AW-1:0] OFS_MASK    = 7'h04;
    localparam logic [AW-1:0] OFS_SETNUM  = 7'h08;
    localparam logic [AW-1:0] OFS_CLRNUM  = 7'h0C;
    localparam logic [AW-1:0] OFS_EN_HI   = 7'h10;
    localparam logic [AW-1:0] OFS_EN_LO   = 7'h14;
    localparam logic [AW-1:0] OFS_TYP_HI  = 7'h18;
    localparam logic [AW-1:0] OFS_TYP_LO  = 7'h1C;
    localparam logic [AW-1:0] OFS_NVEC    = 7'h40;
    localparam logic [AW-1:0] OFS_FVEC    = 7'h44;
    localparam logic [AW-1:0] OFS_RAW_HI  = 7'h48;
    localparam logic [AW-1:0] OFS_RAW_LO  = 7'h4C;
    localparam logic [AW-1:0] OFS_FRC_HI  = 7'h50;
    localparam logic [AW-1:0] OFS_FRC_LO  = 7'h54;
    localparam logic [AW-1:0] OFS_NPND_HI = 7'h58;
    localparam logic [AW-1:0] OFS_NPND_LO = 7'h5C;
    localparam logic [AW-1:0] OFS_FPND_HI = 7'h60;
    localparam logic [AW-1:0] OFS_FPND_LO = 7'h64;

    localparam logic [15:0] VEC_NONE = 16'hFFFF;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_ACK  = 1'b1
    } bus_state_t;
endpackage

// File: rtl/vic_bus_fsm.sv
module vic_bus_fsm
    import vic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic we,
    output logic ack,
    output logic wr_stb,
    output logic rd_stb
);
    bus_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        ack     = 1'b0;
        wr_stb  = 1'b0;
        rd_stb  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (req) begin
                    wr_stb  = we;
                    rd_stb  = !we;
                    state_d = S_ACK;
                end
            end
            S_ACK: begin
                ack     = 1'b1;
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    p_ack_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    p_ack_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(req));
    p_no_take_in_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !(wr_stb || rd_stb));
endmodule

// File: rtl/vic_prio_arb.sv
module vic_prio_arb #(
    parameter int N  = 64,
    parameter int PW = 4,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]    cand,
    input  logic [N*PW-1:0] prio,
    output logic            win_valid,
    output logic [IW-1:0]   win_idx,
    output logic [PW-1:0]   win_prio
);
    // key = {candidate, priority, index}: one compare orders by
    // presence, then priority, then higher index
    localparam int KW = 1 + PW + IW;
    localparam int NODES = 2 * N - 1;

    logic [KW-1:0] leaf [N];
    logic [KW-1:0] node [NODES];

    for (genvar g = 0; g < N; g++) begin : g_leaf
        assign leaf[g] = {cand[g], prio[g*PW +: PW], IW'(g)};
    end

    always_comb begin
        for (int i = 0; i < N; i++) node[N-1+i] = leaf[i];
        for (int k = N - 2; k >= 0; k--) begin
            node[k] = (node[2*k+1] > node[2*k+2]) ? node[2*k+1] : node[2*k+2];
        end
    end

    assign win_valid = node[0][KW-1];
    assign win_prio  = node[0][KW-2 -: PW];
    assign win_idx   = node[0][IW-1:0];
endmodule

// File: rtl/vic_fast_enc.sv
module vic_fast_enc #(
    parameter int N  = 64,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  pend,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import vic_pkg::*;
#(
    parameter int NUM_SRC = NSRC,
    parameter int DATA_W  = DW,
    parameter int PRIO_BITS = PRIO_W,
    parameter int ADDR_W  = AW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  irq_src,
    input  logic                bus_req,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic                bus_ack,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                irq_norm,
    output logic                irq_fast
);
    localparam int IW      = $clog2(NUM_SRC);
    localparam int MW      = PRIO_BITS + 1;
    localparam int PER_REG = DATA_W / PRIO_BITS;
    localparam int NPREG   = NUM_SRC / PER_REG;
    localparam int HALF    = NUM_SRC / 2;
    localparam logic [MW-1:0] MASK_OFF = '1;

    logic wr_stb, rd_stb;

    logic [DATA_W-1:0]           ctrl_q;
    logic [MW-1:0]               mask_q;
    logic [NUM_SRC-1:0]          en_q, type_q, force_q;
    logic [NPREG-1:0][DATA_W-1:0] prio_q;
    logic [DATA_W-1:0]           rdata_q;

    logic [NUM_SRC-1:0] active, pend, pass, norm_pend, fast_pend;
    logic               win_valid, fast_found;
    logic [IW-1:0]      win_idx, fast_idx;
    logic [PRIO_BITS-1:0] win_prio;
    logic [DATA_W-1:0]  norm_vec, fast_vec, rd_val;
    logic               num_ok;
    logic [$clog2(NPREG)-1:0] prio_sel;

    vic_bus_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (bus_req),
        .we     (bus_we),
        .ack    (bus_ack),
        .wr_stb (wr_stb),
        .rd_stb (rd_stb)
    );

    assign num_ok   = (bus_wdata[DATA_W-1:IW] == '0);
    assign prio_sel = $clog2(NPREG)'(NPREG - 1) - bus_addr[4:2];

    // register writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            mask_q  <= MASK_OFF;
            en_q    <= '0;
            type_q  <= '0;
            force_q <= '0;
            prio_q  <= '0;
        end else if (wr_stb) begin
            case (bus_addr)
                OFS_CTRL:   ctrl_q <= bus_wdata;
                OFS_MASK:   mask_q <= bus_wdata[MW-1:0];
                OFS_SETNUM: if (num_ok) en_q[bus_wdata[IW-1:0]] <= 1'b1;
                OFS_CLRNUM: if (num_ok) en_q[bus_wdata[IW-1:0]] <= 1'b0;
                OFS_EN_HI:  en_q[NUM_SRC-1:HALF]    <= bus_wdata;
                OFS_EN_LO:  en_q[HALF-1:0]          <= bus_wdata;
                OFS_TYP_HI: type_q[NUM_SRC-1:HALF]  <= bus_wdata;
                OFS_TYP_LO: type_q[HALF-1:0]        <= bus_wdata;
                OFS_FRC_HI: force_q[NUM_SRC-1:HALF] <= bus_wdata;
                OFS_FRC_LO: force_q[HALF-1:0]       <= bus_wdata;
                default: begin
                    if (bus_addr[6:5] == 2'b01 && bus_addr[1:0] == 2'b00)
                        prio_q[prio_sel] <= bus_wdata;
                end
            endcase
        end
    end

    // activity, routing and priority masking
    assign active    = irq_src | force_q;
    assign pend      = active & en_q;
    assign fast_pend = pend & type_q;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_mask
        assign pass[g] = (mask_q == MASK_OFF) ||
                         ({1'b0, prio_q[g/PER_REG][(g%PER_REG)*PRIO_BITS +: PRIO_BITS]} > mask_q);
    end
    assign norm_pend = pend & ~type_q & pass;

    vic_prio_arb #(.N(NUM_SRC), .PW(PRIO_BITS), .IW(IW)) u_arb (
        .cand      (norm_pend),
        .prio      (prio_q),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_prio  (win_prio)
    );

    vic_fast_enc #(.N(NUM_SRC), .IW(IW)) u_fenc (
        .pend  (fast_pend),
        .found (fast_found),
        .idx   (fast_idx)
    );

    assign norm_vec = win_valid  ? {(16-IW)'(0), win_idx, (16-PRIO_BITS)'(0), win_prio}
                                 : {VEC_NONE, 16'h0000};
    assign fast_vec = fast_found ? {(16-IW)'(0), fast_idx, 16'h0000}
                                 : {VEC_NONE, 16'h0000};

    assign irq_norm = |norm_pend;
    assign irq_fast = |fast_pend;

    // read mux
    always_comb begin
        rd_val = '0;
        case (bus_addr)
            OFS_CTRL:    rd_val = ctrl_q;
            OFS_MASK:    rd_val = DATA_W'(mask_q);
            OFS_EN_HI:   rd_val = en_q[NUM_SRC-1:HALF];
            OFS_EN_LO:   rd_val = en_q[HALF-1:0];
            OFS_TYP_HI:  rd_val = type_q[NUM_SRC-1:HALF];
            OFS_TYP_LO:  rd_val = type_q[HALF-1:0];
            OFS_NVEC:    rd_val = norm_vec;
            OFS_FVEC:    rd_val = fast_vec;
            OFS_RAW_HI:  rd_val = irq_src[NUM_SRC-1:HALF];
            OFS_RAW_LO:  rd_val = irq_src[HALF-1:0];
            OFS_FRC_HI:  rd_val = force_q[NUM_SRC-1:HALF];
            OFS_FRC_LO:  rd_val = force_q[HALF-1:0];
            OFS_NPND_HI: rd_val = norm_pend[NUM_SRC-1:HALF];
            OFS_NPND_LO: rd_val = norm_pend[HALF-1:0];
            OFS_FPND_HI: rd_val = fast_pend[NUM_SRC-1:HALF];
            OFS_FPND_LO: rd_val = fast_pend[HALF-1:0];
            default: begin
                if (bus_addr[6:5] == 2'b01 && bus_addr[1:0] == 2'b00)
                    rd_val = prio_q[prio_sel];
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_stb) rdata_q <= rd_val;
    end
    assign bus_rdata = rdata_q;

    // checks beside the logic they guard
    p_vec_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_norm |-> norm_vec[31:16] == VEC_NONE);
    p_vec_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_norm |-> norm_pend[win_idx]);
    p_fast_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fast |-> fast_pend[fast_idx]);
    p_route_split_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (norm_pend & fast_pend) == '0);
    p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_norm && mask_q != MASK_OFF) |-> ({1'b0, win_prio} > mask_q));
    p_setnum_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && bus_addr == OFS_SETNUM && num_ok) |=> en_q[$past(bus_wdata[IW-1:0])]);
    p_clrnum_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && bus_addr == OFS_CLRNUM && num_ok) |=> !en_q[$past(bus_wdata[IW-1:0])]);
endmodule

// File: tb/vec_irq_ctrl_bench.sv
`timescale 1ns/1ps
module vec_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_src = '0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ack;
    logic [31:0] bus_rdata;
    logic        irq_norm, irq_fast;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vec_irq_ctrl u_vec_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .irq_norm(irq_norm), .irq_fast(irq_fast)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_op(input logic we, input logic [6:0] a, input logic [31:0] d,
                          output logic [31:0] rd);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        rd = bus_rdata;
        bus_req = 1'b0;
        @(negedge clk);
    endtask

    // {we, addr, wdata, expected read, requirement}
    localparam int NT = 38;
    localparam logic [76:0] TBL [NT] = '{
        {1'b0, 8'h40, 32'h0, 32'hFFFF0000, 4'd1},  // R1 no vector
        {1'b0, 8'h00, 32'h0, 32'h00000000, 4'd1},  // R1 control
        {1'b0, 8'h18, 32'h0, 32'h00000000, 4'd1},  // R1 routing
        {1'b0, 8'h2C, 32'h0, 32'h00000000, 4'd1},  // R1 priority
        {1'b0, 8'h50, 32'h0, 32'h00000000, 4'd1},  // R1 force
        {1'b1, 8'h08, 32'd5, 32'h0, 4'd10},        // R10 set 5
        {1'b1, 8'h08, 32'd40, 32'h0, 4'd10},       // R10 set 40
        {1'b1, 8'h08, 32'd64, 32'h0, 4'd10},       // R10 ignored
        {1'b0, 8'h14, 32'h0, 32'h00000020, 4'd10}, // R10 low half
        {1'b0, 8'h10, 32'h0, 32'h00000100, 4'd3},  // R3 high half at lower offset
        {1'b1, 8'h54, 32'h20, 32'h0, 4'd4},        // R4 force 5
        {1'b0, 8'h40, 32'h0, 32'h00050000, 4'd4},  // R4 forced line wins
        {1'b1, 8'h50, 32'h100, 32'h0, 4'd7},       // force 40
        {1'b0, 8'h40, 32'h0, 32'h00280000, 4'd7},  // R7 tie -> higher number
        {1'b1, 8'h3C, 32'h00300000, 32'h0, 4'd6},  // R6 line 5 prio 3
        {1'b0, 8'h40, 32'h0, 32'h00050003, 4'd7},  // R7 priority beats number
        {1'b0, 8'h5C, 32'h0, 32'h00000020, 4'd3},  // R3 normal pending low
        {1'b0, 8'h58, 32'h0, 32'h00000100, 4'd3},  // R3 normal pending high
        {1'b1, 8'h04, 32'd3, 32'h0, 4'd8},         // mask = winner prio
        {1'b0, 8'h40, 32'h0, 32'hFFFF0000, 4'd8},  // R8 inclusive threshold
        {1'b0, 8'h5C, 32'h0, 32'h00000000, 4'd8},  // R8 pending masked
        {1'b1, 8'h04, 32'd2, 32'h0, 4'd8},
        {1'b0, 8'h40, 32'h0, 32'h00050003, 4'd8},  // R8 prio 3 above 2
        {1'b1, 8'h04, 32'h1F, 32'h0, 4'd8},
        {1'b1, 8'h1C, 32'h20, 32'h0, 4'd5},        // R5 line 5 fast
        {1'b0, 8'h44, 32'h0, 32'h00050000, 4'd9},  // R9 fast vector
        {1'b0, 8'h40, 32'h0, 32'h00280000, 4'd5},  // R5 gone from normal
        {1'b0, 8'h64, 32'h0, 32'h00000020, 4'd5},  // R5 fast pending
        {1'b1, 8'h0C, 32'd5, 32'h0, 4'd10},        // clear 5
        {1'b0, 8'h44, 32'h0, 32'hFFFF0000, 4'd9},  // R9 none
        {1'b0, 8'h14, 32'h0, 32'h00000000, 4'd10},
        {1'b0, 8'h08, 32'h0, 32'h00000000, 4'd10}, // R10 reads 0
        {1'b1, 8'h0C, 32'd99, 32'h0, 4'd10},       // R10 ignored
        {1'b0, 8'h10, 32'h0, 32'h00000100, 4'd10},
        {1'b0, 8'h70, 32'h0, 32'h00000000, 4'd2},  // R2 unused offset
        {1'b1, 8'h40, 32'h12345678, 32'h0, 4'd2},  // R2 read-only write
        {1'b0, 8'h40, 32'h0, 32'h00280000, 4'd2},
        {1'b1, 8'h20, 32'hF0000000, 32'h0, 4'd6}   // R6 group 7 lowest offset
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq_norm", {31'b0, irq_norm}, 32'h0);
        chk("R1 irq_fast", {31'b0, irq_fast}, 32'h0);
        chk("R1 ack", {31'b0, bus_ack}, 32'h0);

        // acknowledge timing, R2 and R12
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 7'h04;
        @(negedge clk);
        chk("R2 ack", {31'b0, bus_ack}, 32'h1);
        chk("R1 mask", bus_rdata, 32'h1F);
        @(negedge clk);
        chk("R12 ack drop", {31'b0, bus_ack}, 32'h0);
        @(negedge clk);
        chk("R12 reissue ack", {31'b0, bus_ack}, 32'h1);
        bus_req = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NT; i++) begin
            bus_op(TBL[i][76], TBL[i][74:68], TBL[i][67:36], rd);
            if (!TBL[i][76])
                chk($sformatf("R%0d table %0d", TBL[i][3:0], i), rd, TBL[i][35:4]);
        end
        bus_op(1'b0, 7'h20, 32'h0, rd); chk("R6 readback", rd, 32'hF0000000);
        bus_op(1'b0, 7'h3C, 32'h0, rd); chk("R6 group 0", rd, 32'h00300000);
        bus_op(1'b1, 7'h00, 32'hA5A5A5A5, rd);
        bus_op(1'b0, 7'h00, 32'h0, rd); chk("R2 control", rd, 32'hA5A5A5A5);

        // forces off: outputs drop
        bus_op(1'b1, 7'h50, 32'h0, rd);
        bus_op(1'b1, 7'h54, 32'h0, rd);
        chk("R11 norm idle", {31'b0, irq_norm}, 32'h0);
        chk("R11 fast idle", {31'b0, irq_fast}, 32'h0);

        // pin drives line 40
        irq_src[40] = 1'b1;
        @(negedge clk);
        chk("R4 pin norm", {31'b0, irq_norm}, 32'h1);
        bus_op(1'b0, 7'h48, 32'h0, rd); chk("R4 raw high", rd, 32'h00000100);
        bus_op(1'b0, 7'h4C, 32'h0, rd); chk("R4 raw low", rd, 32'h0);

        // line 63 at priority 15
        bus_op(1'b1, 7'h08, 32'd63, rd);
        irq_src[63] = 1'b1;
        bus_op(1'b0, 7'h40, 32'h0, rd); chk("R7 line 63", rd, 32'h003F000F);

        // two fast lines, lowest wins
        bus_op(1'b1, 7'h08, 32'd5, rd);
        bus_op(1'b1, 7'h08, 32'd2, rd);
        bus_op(1'b1, 7'h1C, 32'h24, rd);
        irq_src[5] = 1'b1; irq_src[2] = 1'b1;
        @(negedge clk);
        chk("R11 fast high", {31'b0, irq_fast}, 32'h1);
        bus_op(1'b0, 7'h44, 32'h0, rd); chk("R9 lowest", rd, 32'h00020000);

        // mask just below off: all normal gone, fast stays
        bus_op(1'b1, 7'h04, 32'h1E, rd);
        chk("R8 norm masked", {31'b0, irq_norm}, 32'h0);
        chk("R8 fast unmasked", {31'b0, irq_fast}, 32'h1);
        bus_op(1'b0, 7'h40, 32'h0, rd); chk("R8 vector", rd, 32'hFFFF0000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule